// File: doc/BRIEF.md
# Four-Step Semaphore Rendezvous Engine

This block coordinates a group of compute cores with a fixed sequence of four rendezvous steps built on shared counting semaphores. In each step the engine first announces its arrival by sending an increment request for each of up to four remote semaphore addresses. It then watches up to four local semaphores. When a watched semaphore reaches that step's target value, the engine asks the semaphore owner to subtract the target from it. The next step begins only after every watched semaphore has met its target.

A typical setup uses the step shape 1, 4, 4, 1. The first step arrives locally, the second signals up to four group leaders, the third waits on four peers, and the last releases locally. Every step takes its own peer count and wait count, so any shape from zero to four per phase can be programmed. A phase with a count of zero is skipped. The transport that carries increments to remote cores and any address translation lie outside the block. The increment port is a plain valid/ready handshake, and decrements are single-cycle pulses to the local semaphore owner.

A start pulse launches the sequence. A flag reports successful completion. A programmable cycle limit can abort a barrier that never completes, and in that case an error flag is raised instead of the completion flag.

Top module: `sem_barrier4`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, err, inc_valid and every dec_valid bit are 0.
- R2: A start pulse seen while busy is 0 clears done and err, sets busy on the next cycle and runs steps 0, 1, 2, 3 in that order.
- R3: In each step the engine sends one increment for each of its first N peer addresses, in ascending slot order, one per cycle in which inc_valid and inc_ready are both 1. N is the step's peer count. While inc_ready is 0, inc_valid and inc_addr hold their values. The address for step s, slot j is cfg_peer_addr[(s*4+j)*64 +: 64], and the peer count of step s is cfg_peer_cnt[s*3 +: 3].
- R4: A peer or wait count above 4 acts as 4. A count of 0 skips that phase of the step.
- R5: For each watched slot k below the step's wait count (cfg_wait_cnt[s*3 +: 3]), the engine raises dec_valid[k] for exactly one cycle, with dec_amt[k*32 +: 32] equal to the target cfg_wait_tgt[(s*4+k)*32 +: 32]. It does this only after the unsigned value sem_val[k*32 +: 32] is at least the target.
- R6: A step ends only when every watched slot has met its target. No increment of a later step is sent before then.
- R7: When step 3 ends, done becomes 1 and busy becomes 0 on the same edge. done stays 1 until the next accepted start, and no requests are issued while busy is 0.
- R8: A start pulse while busy is 1 has no effect on the sequence in progress.
- R9: If cfg_timeout is nonzero and busy has been 1 for cfg_timeout cycles without finishing, the engine aborts. busy falls, err becomes 1, done stays 0 and no further requests are issued. A cfg_timeout of 0 disables the limit.
- R10: done and err are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| cfg_peer_addr | input | 1024 | Remote semaphore addresses, 4 steps by 4 slots, 64 bits each |
| cfg_peer_cnt | input | 12 | Increments per step, 3 bits per step |
| cfg_wait_tgt | input | 512 | Target values, 4 steps by 4 slots, 32 bits each |
| cfg_wait_cnt | input | 12 | Watched slots per step, 3 bits per step |
| cfg_timeout | input | 24 | Abort limit in cycles, 0 disables it |
| inc_valid | output | 1 | Increment request valid |
| inc_addr | output | 64 | Address of the semaphore to increment |
| inc_ready | input | 1 | Increment request accepted |
| sem_val | input | 128 | Current values of the four local semaphores |
| dec_valid | output | 4 | One-cycle decrement pulse per local semaphore |
| dec_amt | output | 128 | Amount to subtract per local semaphore |
| busy | output | 1 | Barrier in progress |
| done | output | 1 | Barrier completed |
| err | output | 1 | Barrier aborted by timeout |

## Verification
The checks take for granted that only the engine's own decrement pulses lower a local semaphore. Remote arrivals may only raise a value, and they never wrap it. Under that assumption, a semaphore that has met its target still meets it when the pulse lands. The bench holds to this by modelling each semaphore as a counter that only adds stimulus amounts and subtracts the engine's pulses. Preloads and bumps stay far below the 32-bit limit, and inc_ready is either held high or toggled each cycle, so requests are stalled and then accepted.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
    localparam int NSTEP  = 4;
    localparam int NSLOT  = 4;
    localparam int STEP_W = $clog2(NSTEP);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int CNT_W  = $clog2(NSLOT + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARRIVE,
        ST_WAIT
    } rdv_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] peers;
        logic [CNT_W-1:0] waits;
    } step_cnt_t;

    // Limit a raw per-step count to the number of slots
    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] raw);
        if (raw > CNT_W'(NSLOT)) return CNT_W'(NSLOT);
        return raw;
    endfunction
endpackage

// File: rtl/rdv_step_sel.sv
module rdv_step_sel import rdv_pkg::*; #(
    parameter int ADDR_W = 64,
    parameter int VAL_W  = 32
) (
    input  logic [STEP_W-1:0]             step,
    input  logic [NSTEP*NSLOT*ADDR_W-1:0] peer_addr_all,
    input  logic [NSTEP*NSLOT*VAL_W-1:0]  tgt_all,
    input  logic [NSTEP*CNT_W-1:0]        peer_cnt_all,
    input  logic [NSTEP*CNT_W-1:0]        wait_cnt_all,
    output logic [NSLOT*ADDR_W-1:0]       peer_addr,
    output logic [NSLOT*VAL_W-1:0]        tgt,
    output step_cnt_t                     cnt
);
    localparam int ROW_A = NSLOT * ADDR_W;
    localparam int ROW_T = NSLOT * VAL_W;

    assign peer_addr = peer_addr_all[32'(step)*ROW_A +: ROW_A];
    assign tgt       = tgt_all[32'(step)*ROW_T +: ROW_T];
    assign cnt.peers = clamp_cnt(peer_cnt_all[32'(step)*CNT_W +: CNT_W]);
    assign cnt.waits = clamp_cnt(wait_cnt_all[32'(step)*CNT_W +: CNT_W]);
endmodule

// File: rtl/rdv_wait_unit.sv
module rdv_wait_unit import rdv_pkg::*; #(
    parameter int VAL_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   active,
    input  logic [CNT_W-1:0]       wait_n,
    input  logic [NSLOT*VAL_W-1:0] tgt,
    input  logic [NSLOT*VAL_W-1:0] sem_val,
    output logic [NSLOT-1:0]       dec_valid,
    output logic [NSLOT*VAL_W-1:0] dec_amt,
    output logic                   all_met
);
    logic [NSLOT-1:0] met;
    logic [NSLOT-1:0] watched;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [VAL_W-1:0] tgt_k;
        logic [VAL_W-1:0] sem_k;
        logic [VAL_W-1:0] amt_q;
        logic             met_q;
        logic             pulse_q;
        logic             hit;

        assign tgt_k      = tgt[k*VAL_W +: VAL_W];
        assign sem_k      = sem_val[k*VAL_W +: VAL_W];
        assign watched[k] = CNT_W'(k) < wait_n;
        // a slot fires once: the first cycle its value covers the target
        assign hit        = active && watched[k] && !met_q && (sem_k >= tgt_k);

        always_ff @(posedge clk) begin
            if (rst || !active) begin
                met_q   <= 1'b0;
                pulse_q <= 1'b0;
                amt_q   <= '0;
            end else begin
                pulse_q <= hit;
                if (hit) begin
                    met_q <= 1'b1;
                    amt_q <= tgt_k;
                end
            end
        end

        assign met[k]                     = met_q;
        assign dec_valid[k]               = pulse_q;
        assign dec_amt[k*VAL_W +: VAL_W]  = amt_q;
    end

    assign all_met = &(met | ~watched);
endmodule

// File: rtl/rdv_watchdog.sv
module rdv_watchdog #(
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (run && cnt_q != '1) cnt_q <= cnt_q + TMO_W'(1);
    end

    // a comparison at or past the limit keeps firing if a step change defers the abort
    assign expire = run && (limit != '0) && (cnt_q >= limit - TMO_W'(1));
endmodule

// File: rtl/sem_barrier4.sv
module sem_barrier4 import rdv_pkg::*; #(
    parameter int ADDR_W = 64,
    parameter int VAL_W  = 32,
    parameter int TMO_W  = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [NSTEP*NSLOT*ADDR_W-1:0] cfg_peer_addr,
    input  logic [NSTEP*CNT_W-1:0]        cfg_peer_cnt,
    input  logic [NSTEP*NSLOT*VAL_W-1:0]  cfg_wait_tgt,
    input  logic [NSTEP*CNT_W-1:0]        cfg_wait_cnt,
    input  logic [TMO_W-1:0]              cfg_timeout,
    output logic                          inc_valid,
    output logic [ADDR_W-1:0]             inc_addr,
    input  logic                          inc_ready,
    input  logic [NSLOT*VAL_W-1:0]        sem_val,
    output logic [NSLOT-1:0]              dec_valid,
    output logic [NSLOT*VAL_W-1:0]        dec_amt,
    output logic                          busy,
    output logic                          done,
    output logic                          err
);
    rdv_state_e              state_q;
    logic [STEP_W-1:0]       step_q;
    logic [CNT_W-1:0]        slot_q;
    logic                    done_q;
    logic                    err_q;

    logic [NSLOT*ADDR_W-1:0] cur_addr;
    logic [NSLOT*VAL_W-1:0]  cur_tgt;
    step_cnt_t               cur_cnt;
    logic                    accept;
    logic                    expire;
    logic                    all_met;
    logic                    wait_active;
    logic                    last_step;

    rdv_step_sel #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) u_sel (
        .step          (step_q),
        .peer_addr_all (cfg_peer_addr),
        .tgt_all       (cfg_wait_tgt),
        .peer_cnt_all  (cfg_peer_cnt),
        .wait_cnt_all  (cfg_wait_cnt),
        .peer_addr     (cur_addr),
        .tgt           (cur_tgt),
        .cnt           (cur_cnt)
    );

    assign accept      = start && (state_q == ST_IDLE);
    assign busy        = (state_q != ST_IDLE);
    assign wait_active = (state_q == ST_WAIT) && !expire;
    assign last_step   = (step_q == STEP_W'(NSTEP - 1));

    rdv_watchdog #(.TMO_W(TMO_W)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (busy),
        .limit   (cfg_timeout),
        .expire  (expire)
    );

    rdv_wait_unit #(.VAL_W(VAL_W)) u_wait (
        .clk       (clk),
        .rst       (rst),
        .active    (wait_active),
        .wait_n    (cur_cnt.waits),
        .tgt       (cur_tgt),
        .sem_val   (sem_val),
        .dec_valid (dec_valid),
        .dec_amt   (dec_amt),
        .all_met   (all_met)
    );

    assign inc_valid = (state_q == ST_ARRIVE) && (slot_q < cur_cnt.peers);
    assign inc_addr  = cur_addr[32'(slot_q[SLOT_W-1:0])*ADDR_W +: ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            slot_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_ARRIVE;
                        step_q  <= '0;
                        slot_q  <= '0;
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                    end
                end
                ST_ARRIVE: begin
                    if (slot_q >= cur_cnt.peers) state_q <= ST_WAIT;
                    else if (inc_ready)          slot_q  <= slot_q + CNT_W'(1);
                    if (expire) begin
                        state_q <= ST_IDLE;
                        err_q   <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (all_met) begin
                        if (last_step) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            slot_q  <= '0;
                            state_q <= ST_ARRIVE;
                        end
                    end else if (expire) begin
                        state_q <= ST_IDLE;
                        err_q   <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign err  = err_q;
endmodule

// File: rtl/rdv_checker.sv
module rdv_checker import rdv_pkg::*; #(
    parameter int ADDR_W = 64,
    parameter int VAL_W  = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   inc_valid,
    input logic                   inc_ready,
    input logic [ADDR_W-1:0]      inc_addr,
    input logic [NSLOT*VAL_W-1:0] sem_val,
    input logic [NSLOT-1:0]       dec_valid,
    input logic [NSLOT*VAL_W-1:0] dec_amt,
    input logic                   busy,
    input logic                   done,
    input logic                   err
);
    assert_inc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        inc_valid && !inc_ready |=> err || (inc_valid && $stable(inc_addr)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !inc_valid && (dec_valid == '0));

    assert_done_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(busy));

    assert_abort_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $fell(busy) && !done);

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    for (genvar k = 0; k < NSLOT; k++) begin : g_chk
        assert_dec_cond_R5: assert property (@(posedge clk) disable iff (rst)
            dec_valid[k] |-> sem_val[k*VAL_W +: VAL_W] >= dec_amt[k*VAL_W +: VAL_W]);

        assert_dec_single_R5: assert property (@(posedge clk) disable iff (rst)
            dec_valid[k] |=> !dec_valid[k]);
    end
endmodule

bind sem_barrier4 rdv_checker #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .inc_valid (inc_valid),
    .inc_ready (inc_ready),
    .inc_addr  (inc_addr),
    .sem_val   (sem_val),
    .dec_valid (dec_valid),
    .dec_amt   (dec_amt),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/sim_sem_barrier4.sv
module sim_sem_barrier4;
    import rdv_pkg::*;

    localparam int ADDR_W = 64;
    localparam int VAL_W  = 32;
    localparam int TMO_W  = 24;
    localparam int NV     = 6;
    localparam int LOGN   = 64;

    // fields: [24:13] peer counts, [12:1] wait counts (step 3 first), [0] ready stall
    localparam logic [24:0] VEC [NV] = '{
        {3'd1, 3'd4, 3'd4, 3'd1,  3'd1, 3'd4, 3'd4, 3'd1,  1'b0},
        {3'd1, 3'd4, 3'd4, 3'd1,  3'd1, 3'd4, 3'd4, 3'd1,  1'b1},
        {3'd3, 3'd0, 3'd2, 3'd0,  3'd4, 3'd0, 3'd0, 3'd2,  1'b0},
        {3'd0, 3'd0, 3'd0, 3'd0,  3'd0, 3'd0, 3'd0, 3'd0,  1'b0},
        {3'd4, 3'd4, 3'd4, 3'd4,  3'd4, 3'd4, 3'd4, 3'd4,  1'b1},
        {3'd5, 3'd2, 3'd1, 3'd3,  3'd2, 3'd0, 3'd3, 3'd7,  1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                          rst = 1'b1;
    logic                          start = 1'b0;
    logic [NSTEP*NSLOT*ADDR_W-1:0] cfg_peer_addr = '0;
    logic [NSTEP*CNT_W-1:0]        cfg_peer_cnt = '0;
    logic [NSTEP*NSLOT*VAL_W-1:0]  cfg_wait_tgt = '0;
    logic [NSTEP*CNT_W-1:0]        cfg_wait_cnt = '0;
    logic [TMO_W-1:0]              cfg_timeout = '0;
    logic                          inc_valid;
    logic [ADDR_W-1:0]             inc_addr;
    logic                          inc_ready = 1'b1;
    logic [NSLOT*VAL_W-1:0]        sem_val;
    logic [NSLOT-1:0]              dec_valid;
    logic [NSLOT*VAL_W-1:0]        dec_amt;
    logic                          busy, done, err;

    logic [VAL_W-1:0]  sem [NSLOT];
    logic [VAL_W-1:0]  pre [NSLOT];
    logic [VAL_W-1:0]  add [NSLOT];
    logic [ADDR_W-1:0] log_a [LOGN];
    logic              stall_mode = 1'b0;
    int n_inc = 0;
    int n_chk = 0, n_bad = 0, dec_chk = 0, dec_bad = 0;

    sem_barrier4 #(.ADDR_W(ADDR_W), .VAL_W(VAL_W), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .cfg_peer_addr(cfg_peer_addr), .cfg_peer_cnt(cfg_peer_cnt),
        .cfg_wait_tgt(cfg_wait_tgt), .cfg_wait_cnt(cfg_wait_cnt),
        .cfg_timeout(cfg_timeout),
        .inc_valid(inc_valid), .inc_addr(inc_addr), .inc_ready(inc_ready),
        .sem_val(sem_val), .dec_valid(dec_valid), .dec_amt(dec_amt),
        .busy(busy), .done(done), .err(err)
    );

    always_comb begin
        for (int k = 0; k < NSLOT; k++) sem_val[k*VAL_W +: VAL_W] = sem[k];
    end

    // local semaphore model: bench bumps add, engine pulses subtract
    always @(posedge clk) begin
        for (int k = 0; k < NSLOT; k++) begin
            if (rst) sem[k] <= pre[k];
            else begin
                if (dec_valid[k]) begin
                    dec_chk++;
                    if (sem[k] < dec_amt[k*VAL_W +: VAL_W]) begin
                        dec_bad++;
                        $display("FAIL R5 slot %0d early decrement: actual value %0d expected >= %0d",
                                 k, sem[k], dec_amt[k*VAL_W +: VAL_W]);
                    end
                end
                sem[k] <= sem[k] + add[k] - (dec_valid[k] ? dec_amt[k*VAL_W +: VAL_W] : '0);
            end
        end
    end

    // increment log: one entry per accepted handshake
    always @(posedge clk) begin
        if (rst) n_inc <= 0;
        else if (inc_valid && inc_ready) begin
            if (n_inc < LOGN) log_a[n_inc] <= inc_addr;
            n_inc <= n_inc + 1;
        end
    end

    always @(negedge clk) inc_ready <= stall_mode ? ~inc_ready : 1'b1;

    function automatic logic [ADDR_W-1:0] addr_of(int s, int j);
        return 64'hC0DE_5000_0000_0000 | ADDR_W'(s << 8) | ADDR_W'(j);
    endfunction

    function automatic logic [VAL_W-1:0] tgt_of(int s, int k);
        return VAL_W'(3 + s * 5 + k);
    endfunction

    function automatic int clampi(logic [CNT_W-1:0] c);
        return (int'(c) > NSLOT) ? NSLOT : int'(c);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic configure(input logic [11:0] pc, input logic [11:0] wc, input int tmo);
        for (int s = 0; s < NSTEP; s++) begin
            for (int j = 0; j < NSLOT; j++) begin
                cfg_peer_addr[(s*NSLOT+j)*ADDR_W +: ADDR_W] = addr_of(s, j);
                cfg_wait_tgt[(s*NSLOT+j)*VAL_W +: VAL_W]    = tgt_of(s, j);
            end
        end
        cfg_peer_cnt = pc;
        cfg_wait_cnt = wc;
        cfg_timeout  = TMO_W'(tmo);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic bump(input int k, input int v);
        @(negedge clk) add[k] = VAL_W'(v);
        @(negedge clk) add[k] = '0;
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + dec_chk, n_bad + dec_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NSLOT; k++) begin
            pre[k] = '0;
            add[k] = '0;
        end
        configure(12'h000, 12'h000, 0);
        do_reset();
        // R1 reset state
        chk(!busy && !done && !err, "R1", "flags after reset", {busy, done, err}, 0);
        chk(!inc_valid && dec_valid == '0, "R1", "requests after reset", {inc_valid, dec_valid}, 0);

        // table walk: preload covers all targets, final value must be 7 everywhere
        for (int v = 0; v < NV; v++) begin
            logic [11:0] pc;
            logic [11:0] wc;
            int exp_n;
            int first_bad;
            pc = VEC[v][24:13];
            wc = VEC[v][12:1];
            configure(pc, wc, (v == 5) ? 1000 : 0);
            exp_n = 0;
            for (int s = 0; s < NSTEP; s++) exp_n += clampi(pc[s*CNT_W +: CNT_W]);
            for (int k = 0; k < NSLOT; k++) begin
                pre[k] = VAL_W'(7);
                for (int s = 0; s < NSTEP; s++)
                    if (clampi(wc[s*CNT_W +: CNT_W]) > k) pre[k] = pre[k] + tgt_of(s, k);
            end
            stall_mode = VEC[v][0];
            do_reset();
            pulse_start();
            wait_end(2000);
            chk(done && !err && !busy, "R2 R7", $sformatf("vec %0d finish flags", v),
                {busy, done, err}, 3'b010);
            chk(n_inc == exp_n, "R3 R4", $sformatf("vec %0d increment count", v), n_inc, exp_n);
            first_bad = -1;
            begin
                int idx;
                idx = 0;
                for (int s = 0; s < NSTEP; s++)
                    for (int j = 0; j < clampi(pc[s*CNT_W +: CNT_W]); j++) begin
                        if (idx < n_inc && log_a[idx] != addr_of(s, j) && first_bad < 0) first_bad = idx;
                        idx++;
                    end
            end
            chk(first_bad < 0, "R3", $sformatf("vec %0d address order, first bad index", v), first_bad, -1);
            for (int k = 0; k < NSLOT; k++)
                chk(sem[k] == 7, "R5 R4", $sformatf("vec %0d slot %0d final value", v, k), sem[k], 7);
        end
        stall_mode = 1'b0;

        // gating, single decrement, start while busy
        configure({3'd0, 3'd0, 3'd1, 3'd0}, {3'd0, 3'd0, 3'd0, 3'd2}, 0);
        pre[0] = 100; pre[1] = 0; pre[2] = 0; pre[3] = 0;
        do_reset();
        pulse_start();
        repeat (20) @(negedge clk);
        chk(n_inc == 0, "R6", "step 1 increment before step 0 wait met", n_inc, 0);
        chk(busy && !done, "R6", "still busy while slot 1 short", {busy, done}, 2'b10);
        chk(sem[0] == 97, "R5", "slot 0 decremented once", sem[0], 97);
        pulse_start();
        bump(1, 3);
        repeat (10) @(negedge clk);
        chk(sem[1] == 3, "R5", "no decrement below target", sem[1], 3);
        chk(n_inc == 0, "R6", "increment count while waiting", n_inc, 0);
        bump(1, 1);
        wait_end(200);
        chk(done && !err, "R7", "finish after late arrival", {done, err}, 2'b10);
        chk(n_inc == 1, "R8", "increments after ignored start", n_inc, 1);
        chk(sem[0] == 97, "R8", "slot 0 not decremented again", sem[0], 97);
        chk(sem[1] == 0, "R5", "slot 1 after decrement", sem[1], 0);

        // timeout abort
        configure({3'd0, 3'd0, 3'd0, 3'd2}, {3'd0, 3'd0, 3'd0, 3'd1}, 40);
        pre[0] = 0; pre[1] = 0;
        do_reset();
        pulse_start();
        repeat (34) @(negedge clk);
        chk(busy && !err, "R9", "busy before limit", {busy, err}, 2'b10);
        repeat (10) @(negedge clk);
        chk(err && !busy, "R9", "abort after limit", {err, busy}, 2'b10);
        chk(!done, "R10", "done stays low on abort", done, 0);
        chk(!inc_valid && dec_valid == '0, "R9", "no requests after abort", {inc_valid, dec_valid}, 0);
        chk(n_inc == 2, "R9", "increments before abort", n_inc, 2);

        // timeout disabled
        configure({3'd0, 3'd0, 3'd0, 3'd2}, {3'd0, 3'd0, 3'd0, 3'd1}, 0);
        do_reset();
        pulse_start();
        repeat (300) @(negedge clk);
        chk(busy && !err, "R9", "zero limit never aborts", {busy, err}, 2'b10);
        bump(0, 3);
        wait_end(200);
        chk(done && !err && sem[0] == 0, "R7", "finish with zero limit", {done, err}, 2'b10);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk + dec_chk, n_bad + dec_bad);
        $finish;
    end
endmodule